// File: doc/BRIEF.md
# Branch Target Buffer Next-PC Predictor

This block guesses the address to fetch next. It uses only the current fetch address, so it can work in the same cycle as the sequential PC+4 adder and the separate taken/not-taken predictor, before the instruction itself has been read or decoded. It is a small two-way set-associative table. The set is selected by low-order PC bits. Each entry holds the complete PC of a control-transfer instruction as its tag, together with the target address that instruction last went to.

When the full PC matches a valid entry and the direction input says taken, the stored target becomes the next fetch address. In every other case the sequential address is used. Branch resolution writes through a single update port. Updates flagged as non-branch are dropped. The first time a branch appears it misses. After it resolves it is written into the table, so later fetches of it can hit. An update for a PC that is already stored rewrites that entry's target. A new PC goes into a free way if there is one, and otherwise replaces the way marked as least recently used.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so `hit` is 0, `hit_way` is 0 and `next_pc` equals `fetch_pc`+4.
- R2: A hit needs the complete stored PC to equal `fetch_pc`. A different PC that maps to the same set (index = `fetch_pc[5:2]` for the default 16 sets) misses.
- R3: On a hit with `dir_taken`=1, `next_pc` is the stored target.
- R4: On a hit with `dir_taken`=0, `next_pc` is `fetch_pc`+4 and `hit` is still 1.
- R5: On a miss, `next_pc` is `fetch_pc`+4 whatever the value of `dir_taken`, and `hit_way` is 0.
- R6: An update with `upd_is_branch`=0 writes nothing. A later fetch of that PC still misses.
- R7: A write from an update first becomes visible on the cycle after the update. A lookup in the same cycle sees the old contents.
- R8: Two different PCs of one set can be held at the same time, one in each way, and both hit.
- R9: Each set keeps one recency bit. It is updated by lookup hits and by writes, and a write has priority when both touch the same set. A new PC goes into way 0 if way 0 is free, otherwise into way 1 if way 1 is free, otherwise into the least recently used way.
- R10: An update whose PC is already stored overwrites that entry's target in place. The other way of the set is left unchanged.
- R11: `hit_way` gives the way (0 or 1) that holds the matching entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all valid bits and recency bits |
| fetch_pc | input | PC_W | Current fetch address to look up |
| dir_taken | input | 1 | Taken prediction from the direction predictor |
| upd_valid | input | 1 | A resolved control-transfer result is present this cycle |
| upd_pc | input | PC_W | PC of the resolved instruction |
| upd_target | input | PC_W | Target address the instruction actually went to |
| upd_is_branch | input | 1 | Resolved instruction is a branch or jump; only these are written |
| next_pc | output | PC_W | Predicted next fetch address |
| hit | output | 1 | `fetch_pc` matched a valid entry |
| hit_way | output | 1 | Way of the matching entry (0 on a miss) |

## Verification
The assertions assume that `rst_n` is low at time zero and that the update inputs have known values once reset is released. They also assume that a PC is never stored in both ways of a set. That condition holds only because the table checks the update path for an existing match before it allocates, so the stimulus deliberately re-sends updates for PCs that are already resident. The bench keeps `upd_valid` low during reset. It drives only word-aligned addresses, and it crowds three tags into a few sets, so the free-way and least-recently-used replacement paths are each exercised many times.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int NUM_WAYS = 2;
  typedef logic way_t;
endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int SETS  = 16,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [IDX_W-1:0]                  rd_idx,
  input  logic [IDX_W-1:0]                  ua_idx,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  way_t                              wr_way,
  input  logic [PC_W-1:0]                   wr_tag,
  input  logic [PC_W-1:0]                   wr_tgt,
  output logic [NUM_WAYS-1:0]               rd_valid,
  output logic [NUM_WAYS-1:0][PC_W-1:0]     rd_tag,
  output logic [NUM_WAYS-1:0][PC_W-1:0]     rd_tgt,
  output logic [NUM_WAYS-1:0]               ua_valid,
  output logic [NUM_WAYS-1:0][PC_W-1:0]     ua_tag
);
  logic [SETS-1:0][NUM_WAYS-1:0] valid_q;
  logic [PC_W-1:0] tag_q [SETS][NUM_WAYS];
  logic [PC_W-1:0] tgt_q [SETS][NUM_WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx][wr_way] <= wr_tag;
      tgt_q[wr_idx][wr_way] <= wr_tgt;
    end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_port
    assign rd_valid[w] = valid_q[rd_idx][w];
    assign rd_tag[w]   = tag_q[rd_idx][w];
    assign rd_tgt[w]   = tgt_q[rd_idx][w];
    assign ua_valid[w] = valid_q[ua_idx][w];
    assign ua_tag[w]   = tag_q[ua_idx][w];
  end

  // R6
  valid_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/btb_tag_cmp.sv
module btb_tag_cmp
  import btb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_WAYS-1:0]           valid,
  input  logic [NUM_WAYS-1:0][PC_W-1:0] tags,
  input  logic [PC_W-1:0]               pc,
  output logic                          hit_o,
  output way_t                          way_o
);
  logic [NUM_WAYS-1:0] match;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign match[w] = valid[w] && (tags[w] == pc);
  end

  assign hit_o = |match;
  assign way_o = match[1];

  // R10
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/btb_lru.sv
module btb_lru
  import btb_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                touch_en,
  input  logic [IDX_W-1:0]    touch_idx,
  input  way_t                touch_way,
  input  logic                upd_en,
  input  logic [IDX_W-1:0]    upd_idx,
  input  logic                upd_hit,
  input  way_t                upd_hit_way,
  input  logic [NUM_WAYS-1:0] set_valid,
  output way_t                pick_way
);
  // one bit per set: the way to replace next
  logic [SETS-1:0] victim_q;

  always_comb begin
    if (upd_hit)           pick_way = upd_hit_way;
    else if (!set_valid[0]) pick_way = 1'b0;
    else if (!set_valid[1]) pick_way = 1'b1;
    else                   pick_way = victim_q[upd_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim_q <= '0;
    end else begin
      if (touch_en) victim_q[touch_idx] <= ~touch_way;
      if (upd_en)   victim_q[upd_idx]   <= ~pick_way;
    end
  end

  // R9
  free_way_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_hit && !(&set_valid)) |-> !set_valid[pick_way]);
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int SETS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            dir_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_is_branch,
  output logic [PC_W-1:0] next_pc,
  output logic            hit,
  output logic            hit_way
);
  localparam int IDX_W = $clog2(SETS);
  localparam int LO    = 2;

  function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] p);
    return p + PC_W'(4);
  endfunction

  function automatic logic [IDX_W-1:0] set_of(input logic [PC_W-1:0] p);
    return p[IDX_W+LO-1:LO];
  endfunction

  logic [IDX_W-1:0]              f_idx, u_idx;
  logic [NUM_WAYS-1:0]           f_valid, u_valid;
  logic [NUM_WAYS-1:0][PC_W-1:0] f_tag, f_tgt, u_tag;
  logic                          f_hit, u_hit;
  way_t                          f_way, u_way, pick_way;
  logic                          wr_en;

  assign f_idx = set_of(fetch_pc);
  assign u_idx = set_of(upd_pc);
  assign wr_en = upd_valid && upd_is_branch;

  btb_store #(.PC_W(PC_W), .SETS(SETS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(f_idx), .ua_idx(u_idx),
    .wr_en(wr_en), .wr_idx(u_idx), .wr_way(pick_way),
    .wr_tag(upd_pc), .wr_tgt(upd_target),
    .rd_valid(f_valid), .rd_tag(f_tag), .rd_tgt(f_tgt),
    .ua_valid(u_valid), .ua_tag(u_tag)
  );

  btb_tag_cmp #(.PC_W(PC_W)) u_fetch_cmp (
    .clk(clk), .rst_n(rst_n),
    .valid(f_valid), .tags(f_tag), .pc(fetch_pc),
    .hit_o(f_hit), .way_o(f_way)
  );

  btb_tag_cmp #(.PC_W(PC_W)) u_upd_cmp (
    .clk(clk), .rst_n(rst_n),
    .valid(u_valid), .tags(u_tag), .pc(upd_pc),
    .hit_o(u_hit), .way_o(u_way)
  );

  btb_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(f_hit), .touch_idx(f_idx), .touch_way(f_way),
    .upd_en(wr_en), .upd_idx(u_idx),
    .upd_hit(u_hit), .upd_hit_way(u_way),
    .set_valid(u_valid), .pick_way(pick_way)
  );

  assign hit     = f_hit;
  assign hit_way = f_way;
  assign next_pc = (f_hit && dir_taken) ? f_tgt[f_way] : seq_pc(fetch_pc);

  // R2
  full_tag_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (f_tag[hit_way] == fetch_pc));

  // R7
  write_visible_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && fetch_pc == $past(upd_pc)) |-> hit);
endmodule

// File: tb/btb_predictor_test.sv
`timescale 1ns/1ps
module btb_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc, upd_pc, upd_target, next_pc;
  logic        dir_taken, upd_valid, upd_is_branch, hit, hit_way;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  // behavioural model state
  logic [31:0] m_pc  [16][2];
  logic [31:0] m_tgt [16][2];
  bit          m_v   [16][2];
  bit          m_old [16];   // way used least recently

  always #4 clk = ~clk;

  btb_predictor uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .dir_taken(dir_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_is_branch(upd_is_branch), .next_pc(next_pc), .hit(hit), .hit_way(hit_way)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] pc, input logic dir, input logic uv,
                      input logic [31:0] upc, input logic [31:0] utg, input logic ub,
                      input string rq);
    int s, us, w, pick;
    bit eh, found;
    logic [31:0] en;
    fetch_pc = pc; dir_taken = dir; upd_valid = uv;
    upd_pc = upc; upd_target = utg; upd_is_branch = ub;
    #2;
    s = int'(pc[5:2]);
    eh = 1'b0; w = 0;
    for (int k = 0; k < 2; k++) if (m_v[s][k] && m_pc[s][k] == pc) begin eh = 1'b1; w = k; end
    en = (eh && dir) ? m_tgt[s][w] : pc + 32'd4;
    chk(rq, "next_pc", next_pc, en);
    chk(rq, "hit", {31'd0, hit}, {31'd0, eh});
    chk(rq, "hit_way", {31'd0, hit_way}, w);
    // state change at the coming edge
    if (eh) m_old[s] = (w == 0);
    if (uv && ub) begin
      us = int'(upc[5:2]);
      found = 1'b0; pick = 0;
      for (int k = 0; k < 2; k++) if (m_v[us][k] && m_pc[us][k] == upc) begin found = 1'b1; pick = k; end
      if (!found) begin
        if (!m_v[us][0]) pick = 0;
        else if (!m_v[us][1]) pick = 1;
        else pick = m_old[us] ? 1 : 0;
      end
      m_v[us][pick] = 1'b1; m_pc[us][pick] = upc; m_tgt[us][pick] = utg;
      m_old[us] = (pick == 0);
    end
    @(negedge clk);
  endtask

  localparam logic [31:0] PA = 32'h0000_100C;
  localparam logic [31:0] PB = 32'h0000_200C;
  localparam logic [31:0] PC3 = 32'h0000_300C;

  initial begin
    for (int s = 0; s < 16; s++) begin
      m_old[s] = 1'b0;
      for (int k = 0; k < 2; k++) begin m_v[s][k] = 1'b0; m_pc[s][k] = '0; m_tgt[s][k] = '0; end
    end
    rst_n = 1'b0; fetch_pc = PA; dir_taken = 1'b1;
    upd_valid = 1'b0; upd_pc = '0; upd_target = '0; upd_is_branch = 1'b0;
    @(negedge clk); @(negedge clk);
    #2;
    chk("R1", "reset next_pc", next_pc, PA + 32'd4);
    chk("R1", "reset hit", {31'd0, hit}, 32'd0);
    chk("R1", "reset hit_way", {31'd0, hit_way}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(PA, 1'b1, 1'b0, 0, 0, 1'b0, "R5");                 // miss with taken
    step(PA, 1'b1, 1'b1, PA, 32'h5000, 1'b0, "R6");         // non-branch update
    step(PA, 1'b1, 1'b0, 0, 0, 1'b0, "R6");                 // still a miss
    step(PA, 1'b1, 1'b1, PA, 32'h5000, 1'b1, "R7");         // same-cycle lookup: old
    step(PA, 1'b1, 1'b0, 0, 0, 1'b0, "R3");                 // hit way 0 taken
    step(PA, 1'b0, 1'b0, 0, 0, 1'b0, "R4");                 // hit not taken
    step(PB, 1'b1, 1'b0, 0, 0, 1'b0, "R2");                 // alias in set misses
    step(PB, 1'b1, 1'b1, PB, 32'h6000, 1'b1, "R8");
    step(PB, 1'b1, 1'b0, 0, 0, 1'b0, "R11");                // hit in way 1
    step(PA, 1'b1, 1'b0, 0, 0, 1'b0, "R8");                 // A still hits, B now older
    step(PC3, 1'b1, 1'b1, PC3, 32'h7000, 1'b1, "R9");       // evicts B
    step(PB, 1'b1, 1'b0, 0, 0, 1'b0, "R9");                 // B gone
    step(PC3, 1'b1, 1'b0, 0, 0, 1'b0, "R9");                // C in way 1
    step(PA, 1'b1, 1'b1, PA, 32'h5100, 1'b1, "R10");        // overwrite in place
    step(PA, 1'b1, 1'b0, 0, 0, 1'b0, "R10");
    step(PC3, 1'b1, 1'b0, 0, 0, 1'b0, "R10");
    for (int i = 0; i < 60; i++) begin
      step(32'h1000 + 32'((i * 7) % 12) * 4 + (32'(i % 3) << 12), i[0],
           (i % 2 == 0),
           32'h1000 + 32'((i * 5) % 12) * 4 + (32'((i + 1) % 3) << 12),
           32'h8000 + 32'(i) * 16, (i % 4 != 2), "R9");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule